// File: doc/BRIEF.md
# Four-Channel PWM Register Front End

This block is the register-side controller for a group of four pulse-width channels. Software reaches it through a plain memory-mapped read/write port. A few global registers sit at the bottom of the map. The first is a write-one start register, and next to it a write-one stop register. A running-state register lets software poll whether a channel is still active. The last is a flag register that gathers end-of-period events and empties itself when it is read. Above these globals, each channel owns a 32-byte register bank. The front end decodes that window and steers bank writes and reads to the matching channel core, which it instantiates once per channel.

Each channel core is built around a three-state machine. The states are `CH_IDLE`, `CH_RUN` and `CH_STOP`:
- A start request moves `CH_IDLE` to `CH_RUN`.
- A stop request moves `CH_RUN` to `CH_STOP`.
- The end of the current period moves `CH_STOP` to `CH_IDLE`.
- A new start request while stopping moves `CH_STOP` back to `CH_RUN`, which cancels the stop.

A stop request never cuts a period short. The channel's running bit therefore stays high until its last period has finished, and software can poll that bit to learn when the channel is truly quiet. Direct configuration writes are accepted only while a channel is idle. A staged update register lets software change duty or period on a live channel at the next period boundary.

Top module: `pwm_bank_ctrl`

## Requirements
- R1: After reset, every readable register reads zero and every `pwm_out` bit is low.
- R2: Writing the start register (offset 0x04) with bit n set starts channel n, and its running bit (bit n of offset 0x0C) reads 1. A zero bit in that write leaves its channel unchanged.
- R3: Writing the stop register (offset 0x08) with bit n set lets channel n finish its current period. Its running bit stays 1 until that period ends and then reads 0. A stop request for an idle channel, or a zero bit, has no effect.
- R4: Reading the flag register (offset 0x1C) returns, in bit n, whether channel n ended a period since the previous flag read. That read clears all flags.
- R5: An end-of-period event in the same cycle as a flag-register read is kept and shows up in the next flag read.
- R6: Channel n's bank starts at 0x200 + n·0x20. The bank holds mode at +0x00, duty at +0x04, period at +0x08 and a staged update value at +0x10. The mode fields are prescale exponent in bits 3:0, polarity in bit 9 and update target in bit 10. Other mode bits read 0.
- R7: Writes to mode, duty or period are ignored while the channel is running or stopping.
- R8: A write to the update offset goes to duty when mode bit 10 is 0 and to period when it is 1. It takes effect at the end of the current period on a running channel, or at once on an idle channel. Reading the update offset returns the last value written to it.
- R9: Reads of any offset not defined above return 0, and writes to them change nothing.
- R10: One period lasts period × 2^prescale clock cycles. `pwm_out[n]` equals the polarity bit while the channel is idle. While running, it is the inverse of the polarity bit whenever the period counter is at or above duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after `bus_rd` |
| pwm_out | output | NCH | Per-channel waveform |

## Verification
Several behaviours are checked by assertions on every cycle:
- a running bit can only fall in the cycle after an end-of-period event;
- a start request always yields a running channel;
- an idle channel drives its polarity level;
- direct configuration writes leave a live channel's registers untouched;
- a flag read leaves only same-cycle events behind, and those events are never dropped;
- undefined reads return zero.

The bench scenarios cover what needs a sequence of accesses. It holds the flag register under continuous reads and counts events to check the period length and prescale. It polls a stopping channel before and after its period boundary. It watches a staged update stay pending and then land, and it confirms the bank address decode and the mode field positions.

// File: rtl/pwm_fe_pkg.sv
package pwm_fe_pkg;
    // Global register offsets (bytes)
    localparam int GLB_START = 'h04;
    localparam int GLB_STOP  = 'h08;
    localparam int GLB_RUN   = 'h0C;
    localparam int GLB_FLAG  = 'h1C;

    // Channel bank window
    localparam int BANK_BASE = 'h200;
    localparam int BANK_LSB  = 5;          // 0x20 bytes per bank

    // Offsets inside a bank
    localparam int CH_MODE   = 'h00;
    localparam int CH_DUTY   = 'h04;
    localparam int CH_PERIOD = 'h08;
    localparam int CH_STAGE  = 'h10;

    // Mode word fields
    localparam int MODE_PRE_W   = 4;
    localparam int MODE_POL_BIT = 9;
    localparam int MODE_SEL_BIT = 10;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_STOP = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pwm_fe_flags.sv
module pwm_fe_flags #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] eop,
    input  logic           rd_clr,
    output logic [NCH-1:0] flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (rd_clr ? '0 : flags) | eop;
        end
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((flags & ~$past(eop)) == '0)); // R4

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|eop) |=> ((flags & $past(eop)) == $past(eop))); // R5
endmodule

// File: rtl/pwm_fe_chan.sv
module pwm_fe_chan
    import pwm_fe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                stop,
    input  logic                wr_en,
    input  logic [BANK_LSB-1:0] off,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                running,
    output logic                eop,
    output logic                wave
);
    localparam int OFF_W = BANK_LSB;

    ch_state_e state, state_nx;

    logic [MODE_PRE_W-1:0] mode_pre;
    logic                  mode_pol;
    logic                  mode_sel;
    logic [CNT_W-1:0]      duty, period, stage_val, cnt;
    logic                  stage_vld;
    logic [PRE_W-1:0]      pre_cnt, pre_mask;
    logic                  tick, last, idle;
    logic                  wr_mode, wr_duty, wr_per, wr_stage;
    logic [DATA_W-1:0]     mode_word;
    logic                  unused_wdata;

    assign unused_wdata = ^wdata;

    assign wr_mode  = wr_en && (off == OFF_W'(CH_MODE));
    assign wr_duty  = wr_en && (off == OFF_W'(CH_DUTY));
    assign wr_per   = wr_en && (off == OFF_W'(CH_PERIOD));
    assign wr_stage = wr_en && (off == OFF_W'(CH_STAGE));

    assign idle     = (state == CH_IDLE);
    assign pre_mask = ~({PRE_W{1'b1}} << mode_pre);
    assign tick     = (pre_cnt == pre_mask);
    assign last     = (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, period});
    assign eop      = !idle && tick && last;
    assign running  = !idle;
    assign wave     = (!idle && (cnt >= duty)) ^ mode_pol;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (start && !stop) state_nx = CH_RUN;
            CH_RUN:  if (stop) state_nx = CH_STOP;
            CH_STOP: begin
                if (start && !stop) state_nx = CH_RUN;
                else if (eop)       state_nx = CH_IDLE;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    // Counters and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            cnt       <= '0;
            mode_pre  <= '0;
            mode_pol  <= 1'b0;
            mode_sel  <= 1'b0;
            duty      <= '0;
            period    <= '0;
            stage_val <= '0;
            stage_vld <= 1'b0;
        end else begin
            if (idle) begin
                pre_cnt <= '0;
                cnt     <= '0;
            end else if (tick) begin
                pre_cnt <= '0;
                cnt     <= last ? '0 : cnt + CNT_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end

            if (idle) begin
                if (wr_mode) begin
                    mode_pre <= wdata[MODE_PRE_W-1:0];
                    mode_pol <= wdata[MODE_POL_BIT];
                    mode_sel <= wdata[MODE_SEL_BIT];
                end
                if (wr_duty) duty   <= wdata[CNT_W-1:0];
                if (wr_per)  period <= wdata[CNT_W-1:0];
            end

            if (wr_stage) begin
                stage_val <= wdata[CNT_W-1:0];
                if (idle) begin
                    stage_vld <= 1'b0;
                    if (mode_sel) period <= wdata[CNT_W-1:0];
                    else          duty   <= wdata[CNT_W-1:0];
                end else begin
                    stage_vld <= 1'b1;
                end
            end else if (eop && stage_vld) begin
                stage_vld <= 1'b0;
                if (mode_sel) period <= stage_val;
                else          duty   <= stage_val;
            end
        end
    end

    always_comb begin
        mode_word = '0;
        mode_word[MODE_PRE_W-1:0] = mode_pre;
        mode_word[MODE_POL_BIT]   = mode_pol;
        mode_word[MODE_SEL_BIT]   = mode_sel;
    end

    always_comb begin
        case (off)
            OFF_W'(CH_MODE):   rdata = mode_word;
            OFF_W'(CH_DUTY):   rdata = DATA_W'(duty);
            OFF_W'(CH_PERIOD): rdata = DATA_W'(period);
            OFF_W'(CH_STAGE):  rdata = DATA_W'(stage_val);
            default:           rdata = '0;
        endcase
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> running); // R2

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(eop)); // R3

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (wave == mode_pol)); // R10

    AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (wr_mode || wr_duty || wr_per) && !eop) |=>
        ($stable(duty) && $stable(period) && $stable(mode_pre) &&
         $stable(mode_pol) && $stable(mode_sel))); // R7
endmodule

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
    import pwm_fe_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    localparam int TAG_W = ADDR_W - BANK_LSB;

    logic              hit_start, hit_stop, hit_run, hit_flag, hit_any;
    logic [NCH-1:0]    bank_sel, start_req, stop_req, run_vec, eop_vec, flags;
    logic [DATA_W-1:0] ch_rdata [NCH];
    logic [DATA_W-1:0] rd_word;

    assign hit_start = (bus_addr == ADDR_W'(GLB_START));
    assign hit_stop  = (bus_addr == ADDR_W'(GLB_STOP));
    assign hit_run   = (bus_addr == ADDR_W'(GLB_RUN));
    assign hit_flag  = (bus_addr == ADDR_W'(GLB_FLAG));
    assign hit_any   = hit_start || hit_stop || hit_run || hit_flag || (|bank_sel);

    assign start_req = (bus_wr && hit_start) ? bus_wdata[NCH-1:0] : '0;
    assign stop_req  = (bus_wr && hit_stop)  ? bus_wdata[NCH-1:0] : '0;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [TAG_W-1:0] TAG = TAG_W'((BANK_BASE >> BANK_LSB) + g);
        assign bank_sel[g] = (bus_addr[ADDR_W-1:BANK_LSB] == TAG);

        pwm_fe_chan #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W),
            .PRE_W  (PRE_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start_req[g]),
            .stop    (stop_req[g]),
            .wr_en   (bus_wr && bank_sel[g]),
            .off     (bus_addr[BANK_LSB-1:0]),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[g]),
            .running (run_vec[g]),
            .eop     (eop_vec[g]),
            .wave    (pwm_out[g])
        );
    end

    pwm_fe_flags #(.NCH(NCH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .eop    (eop_vec),
        .rd_clr (bus_rd && hit_flag),
        .flags  (flags)
    );

    always_comb begin
        rd_word = '0;
        if (hit_run)  rd_word = DATA_W'(run_vec);
        if (hit_flag) rd_word = DATA_W'(flags);
        for (int i = 0; i < NCH; i++) begin
            if (bank_sel[i]) rd_word = ch_rdata[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit_any) |=> (bus_rdata == '0)); // R9
endmodule

// File: tb/tb_pwm_bank_ctrl.sv
module tb_pwm_bank_ctrl;
    localparam int CLK_PERIOD = 10;

    localparam logic [9:0] A_START = 10'h004;
    localparam logic [9:0] A_STOP  = 10'h008;
    localparam logic [9:0] A_RUN   = 10'h00C;
    localparam logic [9:0] A_FLAG  = 10'h01C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [9:0] bank(input int ch, input int off);
        return 10'(32'h200 + ch * 32'h20 + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_RUN, v);        chk("R1 running after reset", v, 0);
        rd(A_FLAG, v);       chk("R1 flags after reset", v, 0);
        rd(bank(0, 0), v);   chk("R1 mode after reset", v, 0);
        rd(bank(1, 8), v);   chk("R1 period after reset", v, 0);
        chk("R1 pwm_out after reset", 32'(pwm_out), 0);
    endtask

    task automatic t_banks;
        logic [31:0] v;
        wr(bank(2, 0), 32'hFFFF_FFFF);
        rd(bank(2, 0), v);   chk("R6 mode fields ch2", v, 32'h0000_060F);
        wr(bank(2, 0), 0);
        wr(bank(3, 4), 32'h1234);
        rd(bank(3, 4), v);   chk("R6 duty ch3", v, 32'h1234);
        rd(bank(0, 4), v);   chk("R6 duty ch0 untouched", v, 0);
        rd(bank(1, 4), v);   chk("R6 duty ch1 untouched", v, 0);
        wr(bank(3, 4), 0);
    endtask

    task automatic t_undef;
        logic [31:0] v;
        wr(10'h000, 32'hF);
        wr(10'h014, 32'hF);
        wr(10'h1FC, 32'hF);
        rd(A_RUN, v);        chk("R9 undefined writes start nothing", v, 0);
        rd(10'h010, v);      chk("R9 undefined global read", v, 0);
        wr(bank(0, 12), 32'h55);
        rd(bank(0, 12), v);  chk("R9 undefined bank offset read", v, 0);
        rd(bank(0, 4), v);   chk("R9 duty unchanged by undefined write", v, 0);
        rd(10'h280, v);      chk("R9 read beyond last bank", v, 0);
    endtask

    task automatic t_start;
        logic [31:0] v;
        wr(bank(0, 8), 4);
        wr(bank(1, 8), 100);
        wr(A_START, 32'h1);
        rd(A_RUN, v);        chk("R2 ch0 started", v, 32'h1);
        wr(A_START, 32'h2);
        rd(A_RUN, v);        chk("R2 ch1 started, ch0 kept", v, 32'h3);
        wr(A_START, 32'h0);
        rd(A_RUN, v);        chk("R2 zero write no effect", v, 32'h3);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(A_STOP, 32'h2);
        rd(A_RUN, v);        chk("R3 ch1 still running after stop request", v, 32'h3);
        wait_cyc(120);
        rd(A_RUN, v);        chk("R3 ch1 stopped after period end", v, 32'h1);
        wr(A_STOP, 32'h4);
        rd(A_RUN, v);        chk("R3 stop of idle channel no effect", v, 32'h1);
        wr(A_STOP, 32'h0);
        rd(A_RUN, v);        chk("R3 zero stop write no effect", v, 32'h1);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        rd(A_FLAG, v);
        wr(A_STOP, 32'h1);
        wait_cyc(20);
        rd(A_RUN, v);        chk("R3 ch0 stopped", v, 0);
        rd(A_FLAG, v);       chk("R4 flag collected for ch0", v, 32'h1);
        rd(A_FLAG, v);       chk("R4 flags cleared by read", v, 0);
    endtask

    task automatic burst_count(input string req, input int exp);
        int hits = 0;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_FLAG;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (bus_rdata[0]) hits++;
        end
        bus_rd = 1'b0;
        chk(req, 32'(hits), 32'(exp));
    endtask

    task automatic t_burst;
        logic [31:0] v;
        wr(A_START, 32'h1);
        burst_count("R5 events kept under continuous reads (R10 period 4)", 4);
        wr(A_STOP, 32'h1);
        wait_cyc(20);
        wr(bank(0, 0), 32'h1);
        wr(A_START, 32'h1);
        burst_count("R10 prescale 1 doubles period", 2);
        wr(A_STOP, 32'h1);
        wait_cyc(30);
        rd(A_RUN, v);        chk("R3 ch0 idle after burst", v, 0);
        wr(bank(0, 0), 0);
    endtask

    task automatic t_stage;
        logic [31:0] v;
        wr(bank(3, 8), 50);
        wr(bank(3, 4), 10);
        wr(A_START, 32'h8);
        wr(bank(3, 4), 7);
        rd(bank(3, 4), v);   chk("R7 duty write ignored while running", v, 10);
        wr(bank(3, 0), 32'h200);
        rd(bank(3, 0), v);   chk("R7 mode write ignored while running", v, 0);
        wr(bank(3, 16), 20);
        rd(bank(3, 4), v);   chk("R8 staged duty pending", v, 10);
        rd(bank(3, 16), v);  chk("R8 staged value readback", v, 20);
        wait_cyc(60);
        rd(bank(3, 4), v);   chk("R8 staged duty applied at period end", v, 20);
        wr(A_STOP, 32'h8);
        wait_cyc(60);
        rd(A_RUN, v);        chk("R3 ch3 stopped", v, 0);
        wr(bank(3, 0), 32'h400);
        wr(bank(3, 16), 33);
        rd(bank(3, 8), v);   chk("R8 staged period applied at once when idle", v, 33);
        rd(bank(3, 4), v);   chk("R8 duty untouched by period target", v, 20);
    endtask

    task automatic t_wave;
        wr(bank(1, 0), 32'h200);
        chk("R10 idle level follows polarity 1", 32'(pwm_out[1]), 1);
        wr(bank(1, 0), 0);
        chk("R10 idle level follows polarity 0", 32'(pwm_out[1]), 0);
        wr(bank(1, 4), 0);
        wr(bank(1, 8), 10);
        wr(A_START, 32'h2);
        wait_cyc(2);
        chk("R10 active level with zero duty", 32'(pwm_out[1]), 1);
        wr(A_STOP, 32'h2);
        wait_cyc(20);
        chk("R10 inactive again after stop", 32'(pwm_out[1]), 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_banks();
        t_undef();
        t_start();
        t_stop();
        t_flags();
        t_burst();
        t_stage();
        t_wave();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule